// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Line Error Detection

This block takes one asynchronous start-stop serial line and turns it back into parallel characters for a host. It works from a free-running system clock plus a one-cycle strobe that arrives sixteen times per bit period. A falling edge on the idle line starts a frame. The block then samples each bit at its centre and checks the character against the data length and parity settings on the configuration pins.

Finished characters go into receive storage. With the queue option off, the storage is one holding register. With it on, the storage is a first-in-first-out queue of up to 16 characters. The host sees the oldest character on `rd_data`. It removes that character by pulsing `rd_data_stb`.

Four sticky flags report line problems: overrun, parity error, framing error and break. A pulse on `rd_stat_stb` clears all four. Two interrupt requests are formed from this state, each with its own enable: one for data waiting in storage, one for any set line flag.

Top module: `serial_rx_unit`

## Requirements
- R1: A low level on the idle line starts a frame only if the line is still low 8 ticks later, at the start-bit centre. If the line is high at that point, the receiver returns to idle and stores no character.
- R2: The data length is set by `cfg_len`: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Bits arrive least significant first and are sampled every 16 ticks after the start-bit centre. Bits above the configured length read as 0.
- R3: When `cfg_par_en` is 1, one parity bit follows the data. With `cfg_par_odd` at 0, data plus parity must hold an even number of ones; with it at 1, an odd number. A mismatch sets `err_parity` and the character is still stored. When `cfg_par_en` is 0, there is no parity bit and `err_parity` never sets.
- R4: If the first stop bit samples as 0, `err_framing` sets and the character is still stored.
- R5: If the start bit, all data bits, the parity bit (when enabled) and the stop bit all sample as 0, `err_break` sets along with `err_framing`, and one 0x00 character is stored. No new frame begins until the line has returned high.
- R6: With `cfg_fifo_en` at 0, storage is one character. `data_ready` is 1 while a character is held. A pulse on `rd_data_stb` removes the character shown on `rd_data`.
- R7: With `cfg_fifo_en` at 1, up to 16 characters are held. They are read back in arrival order.
- R8: If a character completes while storage is full, that character is discarded, the stored characters are kept, and `err_overrun` sets.
- R9: Once set, the four error flags stay set until a pulse on `rd_stat_stb`, which clears them all. If a new error arrives in the same cycle as the clear, that error stays set.
- R10: `irq_rda` equals `ie_rda` AND `data_ready`.
- R11: `irq_ls` equals `ie_ls` AND (the OR of the four error flags).
- R12: After reset, storage is empty, all flags are 0, both interrupt requests are 0, and the receiver is idle.
- R13: Changing `cfg_fifo_en` empties the storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle strobe at 16 times the bit rate |
| rxd | input | 1 | Serial line; idle level is 1 |
| cfg_len | input | 2 | Data length code (0..3 gives 5..8 bits) |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_fifo_en | input | 1 | 1 selects the 16-entry queue, 0 the single register |
| ie_rda | input | 1 | Enable for the data-available request |
| ie_ls | input | 1 | Enable for the line-status request |
| rd_data_stb | input | 1 | Removes the oldest stored character |
| rd_stat_stb | input | 1 | Clears the four error flags |
| rd_data | output | 8 | Oldest stored character |
| data_ready | output | 1 | Storage holds at least one character |
| err_overrun | output | 1 | Sticky overrun flag |
| err_parity | output | 1 | Sticky parity error flag |
| err_framing | output | 1 | Sticky framing error flag |
| err_break | output | 1 | Sticky break flag |
| irq_rda | output | 1 | Data-available interrupt request |
| irq_ls | output | 1 | Line-status interrupt request |

## Verification
Overrun in queue mode is the hardest condition to reach. It needs 16 unread characters in storage and a 17th arriving, so the bench turns off its automatic reader and sends 17 frames back to back. It then drains the queue to show that the first 16 survived in order. Break is the other hard case: the line must stay low through the stop-bit centre, and the receiver must not re-trigger until the line recovers. The bench holds the line low for well over one character time and then sends a normal character to confirm that reception resumes.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP,
    S_HOLD
  } rx_state_e;

  typedef struct packed {
    logic [7:0] data;
    logic       perr;
    logic       ferr;
    logic       brk;
  } rx_char_t;

endpackage

// File: rtl/srx_framer.sv
module srx_framer
  import srx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx,
  input  logic [1:0] cfg_len,
  input  logic       par_en,
  input  logic       par_odd,
  output logic       done,
  output rx_char_t   ch
);

  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  rx_state_e      state_q, state_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [2:0]     idx_q, idx_d;
  logic [7:0]     data_q, data_d;
  logic           xr_q, xr_d;
  logic           allz_q, allz_d;
  logic           done_d;
  rx_char_t       ch_d;
  logic [2:0]     last_idx;

  assign last_idx = 3'd4 + {1'b0, cfg_len};

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    data_d  = data_q;
    xr_d    = xr_q;
    allz_d  = allz_q;
    done_d  = 1'b0;
    ch_d    = ch;
    case (state_q)
      S_IDLE: begin
        if (tick && !rx) begin
          state_d = S_START;
          cnt_d   = '0;
        end
      end
      S_START: begin
        if (tick) begin
          if (cnt_q == MID) begin
            cnt_d = '0;
            if (!rx) begin
              state_d = S_DATA;
              idx_d   = '0;
              data_d  = '0;
              xr_d    = 1'b0;
              allz_d  = 1'b1;
            end else begin
              state_d = S_IDLE;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      S_DATA: begin
        if (tick) begin
          if (cnt_q == LAST) begin
            cnt_d        = '0;
            data_d[idx_q] = rx;
            xr_d         = xr_q ^ rx;
            allz_d       = allz_q & !rx;
            if (idx_q == last_idx) begin
              state_d = par_en ? S_PAR : S_STOP;
            end else begin
              idx_d = idx_q + 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      S_PAR: begin
        if (tick) begin
          if (cnt_q == LAST) begin
            cnt_d   = '0;
            xr_d    = xr_q ^ rx;
            allz_d  = allz_q & !rx;
            state_d = S_STOP;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      S_STOP: begin
        if (tick) begin
          if (cnt_q == LAST) begin
            cnt_d     = '0;
            done_d    = 1'b1;
            ch_d.data = data_q;
            ch_d.perr = par_en && (xr_q != par_odd);
            ch_d.ferr = !rx;
            ch_d.brk  = allz_q && !rx;
            state_d   = rx ? S_IDLE : S_HOLD;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      S_HOLD: begin
        if (rx) state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      data_q  <= '0;
      xr_q    <= 1'b0;
      allz_q  <= 1'b0;
      done    <= 1'b0;
      ch      <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      data_q  <= data_d;
      xr_q    <= xr_d;
      allz_q  <= allz_d;
      done    <= done_d;
      ch      <= ch_d;
    end
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/srx_store.sv
module srx_store #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fifo_en,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         ovf
);

  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [W-1:0]    mem [DEPTH];
  logic [AW-1:0]   wp_q, wp_d, rp_q, rp_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            mode_q;
  logic            flush, full, do_push, do_pop;
  logic [CNTW-1:0] cap;

  assign cap     = fifo_en ? CNTW'(DEPTH) : CNTW'(1);
  assign flush   = (fifo_en != mode_q);
  assign full    = (cnt_q >= cap);
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign ovf     = push && full && !flush;
  assign rdata   = mem[rp_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wp_d = nxt(wp_q);
      if (do_pop)  rp_d = nxt(rp_q);
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      rp_q   <= '0;
      cnt_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      wp_q   <= wp_d;
      rp_q   <= rp_d;
      cnt_q  <= cnt_d;
      mode_q <= fifo_en;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata;
  end

  // R7
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNTW'(DEPTH));

  // R8
  ovf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !pop && $stable(fifo_en)) |=> ($stable(cnt_q) && $stable(rdata)));

endmodule

// File: rtl/srx_flags.sv
module srx_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic done,
  input  logic perr,
  input  logic ferr,
  input  logic brk,
  input  logic ovf,
  input  logic stat_rd,
  input  logic data_ready,
  input  logic ie_rda,
  input  logic ie_ls,
  output logic oe,
  output logic pe,
  output logic fe,
  output logic bi,
  output logic irq_rda,
  output logic irq_ls
);

  logic oe_d, pe_d, fe_d, bi_d;

  always_comb begin
    oe_d = (oe && !stat_rd) || ovf;
    pe_d = (pe && !stat_rd) || (done && perr);
    fe_d = (fe && !stat_rd) || (done && ferr);
    bi_d = (bi && !stat_rd) || (done && brk);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe <= 1'b0;
      pe <= 1'b0;
      fe <= 1'b0;
      bi <= 1'b0;
    end else begin
      oe <= oe_d;
      pe <= pe_d;
      fe <= fe_d;
      bi <= bi_d;
    end
  end

  assign irq_rda = ie_rda && data_ready;
  assign irq_ls  = ie_ls && (oe || pe || fe || bi);

  // R3
  perr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pe) |-> $past(done));

  // R9
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !done) |=> !(oe || pe || fe || bi));

endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit
  import srx_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int OVS        = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rxd,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_fifo_en,
  input  logic       ie_rda,
  input  logic       ie_ls,
  input  logic       rd_data_stb,
  input  logic       rd_stat_stb,
  output logic [7:0] rd_data,
  output logic       data_ready,
  output logic       err_overrun,
  output logic       err_parity,
  output logic       err_framing,
  output logic       err_break,
  output logic       irq_rda,
  output logic       irq_ls
);

  logic [1:0] rst_sync_q;
  logic       rst_sn;
  logic [1:0] rx_sync_q;
  logic       done, empty, ovf;
  rx_char_t   ch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) rx_sync_q <= 2'b11;
    else         rx_sync_q <= {rx_sync_q[0], rxd};
  end

  srx_framer #(.OVS(OVS)) u_framer (
    .clk     (clk),
    .rst_n   (rst_sn),
    .tick    (tick16),
    .rx      (rx_sync_q[1]),
    .cfg_len (cfg_len),
    .par_en  (cfg_par_en),
    .par_odd (cfg_par_odd),
    .done    (done),
    .ch      (ch)
  );

  srx_store #(.DEPTH(FIFO_DEPTH), .W(8)) u_store (
    .clk     (clk),
    .rst_n   (rst_sn),
    .fifo_en (cfg_fifo_en),
    .push    (done),
    .wdata   (ch.data),
    .pop     (rd_data_stb),
    .rdata   (rd_data),
    .empty   (empty),
    .ovf     (ovf)
  );

  assign data_ready = !empty;

  srx_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_sn),
    .done       (done),
    .perr       (ch.perr),
    .ferr       (ch.ferr),
    .brk        (ch.brk),
    .ovf        (ovf),
    .stat_rd    (rd_stat_stb),
    .data_ready (data_ready),
    .ie_rda     (ie_rda),
    .ie_ls      (ie_ls),
    .oe         (err_overrun),
    .pe         (err_parity),
    .fe         (err_framing),
    .bi         (err_break),
    .irq_rda    (irq_rda),
    .irq_ls     (irq_ls)
  );

endmodule

// File: tb/serial_rx_unit_test.sv
module serial_rx_unit_test;

  localparam int TDIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] cfg_len = 2'd3;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic       cfg_fifo_en = 1'b0;
  logic       ie_rda = 1'b0;
  logic       ie_ls = 1'b0;
  logic       man_rd = 1'b0;
  logic       mon_rd = 1'b0;
  logic       rd_stat_stb = 1'b0;
  logic [7:0] rd_data;
  logic       data_ready, err_overrun, err_parity, err_framing, err_break;
  logic       irq_rda, irq_ls;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int divc = 0;
  bit auto_rd = 1'b0;
  string cur_req = "R6";
  logic [7:0] exp_q[$];

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    divc   <= (divc == TDIV - 1) ? 0 : divc + 1;
    tick16 <= (divc == 0);
  end

  serial_rx_unit uut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_fifo_en(cfg_fifo_en), .ie_rda(ie_rda), .ie_ls(ie_ls),
    .rd_data_stb(man_rd | mon_rd), .rd_stat_stb(rd_stat_stb),
    .rd_data(rd_data), .data_ready(data_ready),
    .err_overrun(err_overrun), .err_parity(err_parity),
    .err_framing(err_framing), .err_break(err_break),
    .irq_rda(irq_rda), .irq_ls(irq_ls)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pops expected characters as the design presents them
  always @(negedge clk) begin
    if (mon_rd) mon_rd = 1'b0;
    else if (auto_rd && data_ready) begin
      if (exp_q.size() == 0) check({cur_req, " unexpected char"}, rd_data, 32'hxx);
      else check({cur_req, " char"}, rd_data, exp_q.pop_front());
      mon_rd = 1'b1;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      bad++; total++;
      $display("FAIL watchdog all requirements act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic drive(input logic b, input int nt);
    rxd = b;
    repeat (nt * TDIV) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] v, input int nb, input bit flip_par, input bit stopv);
    logic p;
    p = cfg_par_odd ^ flip_par;
    drive(1'b0, 16);
    for (int i = 0; i < nb; i++) begin
      drive(v[i], 16);
      p = p ^ v[i];
    end
    if (cfg_par_en) drive(p, 16);
    drive(stopv, 16);
    drive(1'b1, 8);
  endtask

  // driver: queue the expected character, then put the frame on the line
  task automatic send_exp(input logic [7:0] v, input int nb, input bit flip_par, input bit stopv);
    exp_q.push_back(v & 8'((1 << nb) - 1));
    send(v, nb, flip_par, stopv);
  endtask

  task automatic chk_stat(input string tag, input bit oe, input bit pe, input bit fe, input bit bi);
    @(negedge clk);
    check({tag, " flags"}, {err_overrun, err_parity, err_framing, err_break}, {oe, pe, fe, bi});
    rd_stat_stb = 1'b1;
    @(negedge clk);
    rd_stat_stb = 1'b0;
    check({tag, " R9 cleared"}, {err_overrun, err_parity, err_framing, err_break}, 4'b0);
  endtask

  task automatic pop_chk(input string tag, input logic [7:0] exp);
    @(negedge clk);
    check({tag, " ready"}, data_ready, 1'b1);
    check({tag, " data"}, rd_data, exp);
    man_rd = 1'b1;
    @(negedge clk);
    man_rd = 1'b0;
  endtask

  task automatic drain_chk(input string tag);
    drive(1'b1, 4);
    check({tag, " queue drained"}, exp_q.size(), 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R12
    check("R12 ready", data_ready, 1'b0);
    check("R12 flags", {err_overrun, err_parity, err_framing, err_break}, 4'b0);
    check("R12 irqs", {irq_rda, irq_ls}, 2'b0);
    drive(1'b1, 20);

    // R6: single register, scoreboard reads
    auto_rd = 1'b1; cur_req = "R6";
    send_exp(8'hA5, 8, 0, 1);
    send_exp(8'h3C, 8, 0, 1);
    drain_chk("R6");

    // R2: shorter lengths, upper bits zero
    cur_req = "R2";
    cfg_len = 2'd0; send_exp(8'hFF, 5, 0, 1);
    cfg_len = 2'd1; send_exp(8'hEA, 6, 0, 1);
    cfg_len = 2'd2; send_exp(8'hD5, 7, 0, 1);
    cfg_len = 2'd3;
    drain_chk("R2");

    // R3: even and odd parity
    cur_req = "R3";
    cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
    send_exp(8'h5B, 8, 0, 1); chk_stat("R3 even ok", 0, 0, 0, 0);
    send_exp(8'h5B, 8, 1, 1); chk_stat("R3 even bad", 0, 1, 0, 0);
    cfg_par_odd = 1'b1;
    send_exp(8'h07, 8, 0, 1); chk_stat("R3 odd ok", 0, 0, 0, 0);
    send_exp(8'h07, 8, 1, 1); chk_stat("R3 odd bad", 0, 1, 0, 0);
    cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
    drain_chk("R3");

    // R4: framing error
    cur_req = "R4";
    send_exp(8'h42, 8, 0, 0);
    chk_stat("R4", 0, 0, 1, 0);
    drain_chk("R4");

    // R5: break, then recovery
    cur_req = "R5";
    exp_q.push_back(8'h00);
    drive(1'b0, 16 * 14);
    drive(1'b1, 16);
    chk_stat("R5", 0, 0, 1, 1);
    send_exp(8'h81, 8, 0, 1);
    drain_chk("R5");

    // R1: glitch rejected
    cur_req = "R1";
    drive(1'b0, 4);
    drive(1'b1, 40);
    check("R1 no char", data_ready, 1'b0);
    drain_chk("R1");
    chk_stat("R1", 0, 0, 0, 0);

    // R10 / R11: interrupt gating
    auto_rd = 1'b0;
    send(8'h99, 8, 0, 1);
    check("R10 masked", irq_rda, 1'b0);
    ie_rda = 1'b1; @(negedge clk);
    check("R10 enabled", irq_rda, 1'b1);
    pop_chk("R10", 8'h99);
    check("R10 after read", irq_rda, 1'b0);
    cfg_par_en = 1'b1;
    send(8'h10, 8, 1, 1);
    pop_chk("R11", 8'h10);
    check("R11 masked", irq_ls, 1'b0);
    ie_ls = 1'b1; @(negedge clk);
    check("R11 enabled", irq_ls, 1'b1);
    chk_stat("R11", 0, 1, 0, 0);
    check("R11 after clear", irq_ls, 1'b0);
    cfg_par_en = 1'b0; ie_rda = 1'b0; ie_ls = 1'b0;

    // R8: overrun with single register
    send(8'h11, 8, 0, 1);
    send(8'h22, 8, 0, 1);
    check("R8 overrun", err_overrun, 1'b1);
    pop_chk("R8 kept", 8'h11);
    @(negedge clk);
    check("R8 discarded", data_ready, 1'b0);
    chk_stat("R8", 1, 0, 0, 0);

    // R7: 16-entry queue, then overrun on the 17th
    cfg_fifo_en = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 16; i++) send(8'(i * 7 + 3), 8, 0, 1);
    check("R7 no overrun at 16", err_overrun, 1'b0);
    send(8'hEE, 8, 0, 1);
    check("R8 queue overrun", err_overrun, 1'b1);
    for (int i = 0; i < 16; i++) pop_chk("R7 order", 8'(i * 7 + 3));
    @(negedge clk);
    check("R7 empty", data_ready, 1'b0);
    chk_stat("R7", 1, 0, 0, 0);

    // R13: mode change empties storage
    send(8'h5A, 8, 0, 1);
    send(8'hA5, 8, 0, 1);
    check("R13 filled", data_ready, 1'b1);
    cfg_fifo_en = 1'b0;
    repeat (2) @(negedge clk);
    check("R13 flushed", data_ready, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule